// File: doc/BRIEF.md
# Indexed Parameter Mailbox

This block lets a host load a large set of configuration parameters into on-chip memory through three small registers: a data word, an index and a pending flag. The host loads the word and the index, then raises the flag. Commit logic inside the block sees the flag, writes the word into the parameter memory at that index, and then drops the flag. A low flag tells the host it may send the next parameter.

Computation logic reads the stored parameters through its own synchronous read port, at whatever rate it needs. The memory has one writer (the commit logic) and one reader (the read port), so no access arbitration exists anywhere in the block. An index outside the memory is dropped without a write and sets a sticky error bit that the host can read and clear.

Top module: `param_mailbox`

## Requirements
- R1: After reset, `busy_o` and `err_o` are 0 and the data and index registers (`val_q_o`, `idx_q_o`) read 0.
- R2: While `busy_o` is 0, a strobe on `host_val_we_i` or `host_idx_we_i` loads the data or index register, visible on `val_q_o` / `idx_q_o` one cycle later.
- R3: A pulse on `host_go_i` while idle raises `busy_o` in the following cycle. The commit writes `val_q_o` into memory at `idx_q_o` on the next edge, and `busy_o` falls exactly one cycle after that edge, so `busy_o` stays high for exactly two cycles.
- R4: Strobes on `host_val_we_i` or `host_idx_we_i` while `busy_o` is 1 are ignored. The register contents and the value committed to memory stay unchanged.
- R5: A pulse on `host_go_i` while `busy_o` is 1 has no effect. The busy window neither restarts nor lengthens.
- R6: A commit with `idx_q_o` >= DEPTH writes no memory location and sets `err_o`. `err_o` stays set through later valid commits until `host_err_clr_i` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R7: The read port is synchronous. `rd_data_o` shows the word at `rd_addr_i` one cycle after a cycle with `rd_en_i` = 1, and holds its value while `rd_en_i` is 0.
- R8: A read of the address that the commit writes in that same cycle returns the old contents. The new word appears on the next read.
- R9: A read with `rd_addr_i` >= DEPTH returns 0.
- R10: Reset leaves the memory contents intact. A word written before reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_val_we_i | input | 1 | Write strobe for the data register |
| host_val_i | input | DATA_W | New data register value |
| host_idx_we_i | input | 1 | Write strobe for the index register |
| host_idx_i | input | IDX_W | New index register value |
| host_go_i | input | 1 | Sets the pending flag |
| host_err_clr_i | input | 1 | Clears the sticky error bit |
| val_q_o | output | DATA_W | Data register readback |
| idx_q_o | output | IDX_W | Index register readback |
| busy_o | output | 1 | Pending flag; 1 while a transfer is outstanding |
| err_o | output | 1 | Sticky out-of-range index error |
| rd_en_i | input | 1 | Read enable, computation side |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, one cycle latency |

## Verification
The bench builds the block with DATA_W=8, IDX_W=5 and DEPTH=12, so ADDR_W is 4. Because the depth is not a power of two, both the index register (values 12 to 31) and the read address (values 12 to 15) can point past the memory, which makes the dropped-write and zero-read paths reachable. The small depth also lets the bench fill and read back every location, including the last one. Cycle-exact probes pin the two-cycle busy window, a read of the address being written in the commit cycle, and host strobes placed inside the busy window.

// File: rtl/param_mailbox_pkg.sv
package param_mailbox_pkg;
  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_DONE = 1'b1
  } wr_state_e;
endpackage

// File: rtl/param_mailbox_ram.sv
module param_mailbox_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              rd_ok;

  assign rd_ok = {1'b0, raddr_i} < DEPTH_X;

  // no reset on storage
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // nonblocking read of mem_q gives old data on same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (re_i)  rdata_o <= rd_ok ? mem_q[raddr_i] : '0;
  end
endmodule

// File: rtl/param_mailbox_regs.sv
module param_mailbox_regs #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              val_we_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              go_i,
  input  logic              err_clr_i,
  input  logic              done_i,
  input  logic              oob_i,
  output logic [DATA_W-1:0] val_q_o,
  output logic [IDX_W-1:0]  idx_q_o,
  output logic              busy_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q_o <= '0;
      idx_q_o <= '0;
    end else if (!busy_o) begin
      if (val_we_i) val_q_o <= val_i;
      if (idx_we_i) idx_q_o <= idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_o <= 1'b0;
    else if (done_i) busy_o <= 1'b0;
    else if (go_i)   busy_o <= 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         err_o <= 1'b0;
    else if (oob_i)      err_o <= 1'b1;
    else if (err_clr_i)  err_o <= 1'b0;
  end
endmodule

// File: rtl/param_mailbox_writer.sv
module param_mailbox_writer
  import param_mailbox_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              oob_o,
  output logic              done_o
);
  localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);

  wr_state_e state_q;
  logic      issue, in_range;

  assign issue    = busy_i && (state_q == WR_IDLE);
  assign in_range = {1'b0, idx_i} < DEPTH_X;
  assign we_o     = issue && in_range;
  assign oob_o    = issue && !in_range;
  assign waddr_o  = idx_i[ADDR_W-1:0];
  assign wdata_o  = val_i;
  assign done_o   = (state_q == WR_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= WR_IDLE;
    else if (issue)  state_q <= WR_DONE;
    else if (done_o) state_q <= WR_IDLE;
  end
endmodule

// File: rtl/param_mailbox.sv
module param_mailbox #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 24,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_val_we_i,
  input  logic [DATA_W-1:0] host_val_i,
  input  logic              host_idx_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic              host_go_i,
  input  logic              host_err_clr_i,
  output logic [DATA_W-1:0] val_q_o,
  output logic [IDX_W-1:0]  idx_q_o,
  output logic              busy_o,
  output logic              err_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              ram_we, wr_oob, wr_done;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  param_mailbox_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .val_we_i (host_val_we_i),
    .val_i    (host_val_i),
    .idx_we_i (host_idx_we_i),
    .idx_i    (host_idx_i),
    .go_i     (host_go_i),
    .err_clr_i(host_err_clr_i),
    .done_i   (wr_done),
    .oob_i    (wr_oob),
    .val_q_o, .idx_q_o, .busy_o, .err_o
  );

  param_mailbox_writer #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_writer (
    .clk_i, .rst_ni,
    .busy_i (busy_o),
    .val_i  (val_q_o),
    .idx_i  (idx_q_o),
    .we_o   (ram_we),
    .waddr_o(ram_waddr),
    .wdata_o(ram_wdata),
    .oob_o  (wr_oob),
    .done_o (wr_done)
  );

  param_mailbox_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .re_i   (rd_en_i),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/param_mailbox_chk.sv
module param_mailbox_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_go_i,
  input logic              host_err_clr_i,
  input logic [DATA_W-1:0] val_q_o,
  input logic [IDX_W-1:0]  idx_q_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_waddr
);
  localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(DEPTH);

  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(host_go_i));
  // R3
  busy_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o);
  // R4
  val_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(val_q_o) && $stable(idx_q_o)));
  // R3
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> busy_o);
  // R6
  we_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> ({1'b0, ram_waddr} < DEPTH_X));
  // R6
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy_o));
  // R6
  err_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(host_err_clr_i));
  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind param_mailbox param_mailbox_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i, .rst_ni, .host_go_i, .host_err_clr_i, .val_q_o, .idx_q_o,
  .busy_o, .err_o, .rd_en_i, .rd_data_o, .ram_we, .ram_waddr
);

// File: tb/param_mailbox_tb_top.sv
`timescale 1ns/1ps
module param_mailbox_tb_top;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int DEPTH  = 12;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              val_we = 0, idx_we = 0, go = 0, err_clr = 0, rd_en = 0;
  logic [DATA_W-1:0] val_in = '0;
  logic [IDX_W-1:0]  idx_in = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] val_q, rd_data;
  logic [IDX_W-1:0]  idx_q;
  logic              busy, err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  param_mailbox #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_val_we_i(val_we), .host_val_i(val_in),
    .host_idx_we_i(idx_we), .host_idx_i(idx_in),
    .host_go_i(go), .host_err_clr_i(err_clr),
    .val_q_o(val_q), .idx_q_o(idx_q), .busy_o(busy), .err_o(err),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int idx, int val);
    val_we = 1; val_in = DATA_W'(val);
    idx_we = 1; idx_in = IDX_W'(idx);
    tick();
    val_we = 0; idx_we = 0;
  endtask

  task automatic send(int idx, int val);
    load(idx, val);
    go = 1; tick(); go = 0;
    for (int i = 0; i < 10 && busy; i++) tick();
  endtask

  task automatic read(int addr, output int data);
    rd_en = 1; rd_addr = ADDR_W'(addr);
    tick();
    rd_en = 0;
    data = int'(rd_data);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 val", int'(val_q), 0);
    check("R1 idx", int'(idx_q), 0);
  endtask

  task automatic t_regs();
    load(7, 8'h5a);
    check("R2 val", int'(val_q), 8'h5a);
    check("R2 idx", int'(idx_q), 7);
  endtask

  task automatic t_commit();
    int d;
    load(3, 8'hc3);
    go = 1; tick(); go = 0;
    check("R3 busy c1", int'(busy), 1);
    tick();
    check("R3 busy c2", int'(busy), 1);
    tick();
    check("R3 busy c3", int'(busy), 0);
    read(3, d);
    check("R3 data", d, 8'hc3);
    for (int a = 0; a < DEPTH; a++) send(a, a * 7 + 1);
    for (int a = 0; a < DEPTH; a++) begin
      read(a, d);
      check("R3 fill", d, a * 7 + 1);
    end
  endtask

  task automatic t_ignore();
    int d;
    load(4, 8'h11);
    go = 1; tick(); go = 0;
    val_we = 1; val_in = 8'hee; idx_we = 1; idx_in = 5'd5;
    go = 1;  // R5: go while busy
    tick();
    val_we = 0; idx_we = 0; go = 0;
    check("R4 val", int'(val_q), 8'h11);
    check("R4 idx", int'(idx_q), 4);
    check("R5 busy c2", int'(busy), 1);
    tick();
    check("R5 busy c3", int'(busy), 0);
    tick();
    check("R5 stays low", int'(busy), 0);
    read(4, d);
    check("R4 mem", d, 8'h11);
    read(5, d);
    check("R4 mem other", d, 5 * 7 + 1);
  endtask

  task automatic t_oob();
    int d;
    send(DEPTH, 8'h99);
    check("R6 err set", int'(err), 1);
    send(20, 8'h98);
    send(2, 8'h22);
    check("R6 sticky", int'(err), 1);
    read(2, d);
    check("R6 valid after", d, 8'h22);
    for (int a = 0; a < DEPTH; a++) begin
      if (a == 2 || a == 3 || a == 4) continue;
      read(a, d);
      check("R6 no write", d, a * 7 + 1);
    end
    err_clr = 1; tick(); err_clr = 0;
    check("R6 clear", int'(err), 0);
    // set and clear in same cycle: set wins
    load(31, 8'h01);
    go = 1; tick(); go = 0;
    err_clr = 1; tick(); err_clr = 0;
    check("R6 set wins", int'(err), 1);
    tick();
    err_clr = 1; tick(); err_clr = 0;
    check("R6 clear2", int'(err), 0);
  endtask

  task automatic t_read();
    int d;
    read(6, d);
    check("R7 latency", d, 6 * 7 + 1);
    rd_addr = 4'd7;
    tick();
    check("R7 hold", int'(rd_data), 6 * 7 + 1);
    read(7, d);
    check("R7 next", d, 7 * 7 + 1);
    read(DEPTH, d);
    check("R9 oob read", d, 0);
    read(15, d);
    check("R9 top addr", d, 0);
  endtask

  task automatic t_collide();
    int d;
    load(9, 8'hab);
    go = 1; tick(); go = 0;
    rd_en = 1; rd_addr = 4'd9;
    tick();  // commit edge
    rd_en = 0;
    check("R8 old data", int'(rd_data), 9 * 7 + 1);
    tick();
    read(9, d);
    check("R8 new data", d, 8'hab);
  endtask

  task automatic t_keep();
    int d;
    send(11, 8'h3c);
    rst_n = 0; tick(); rst_n = 1; tick();
    check("R1 busy after rst", int'(busy), 0);
    read(11, d);
    check("R10 kept", d, 8'h3c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_commit();
    t_ignore();
    t_oob();
    t_read();
    t_collide();
    t_keep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule